// File: doc/BRIEF.md
# DDR3 Power-Up Reset Sequencer

This block takes an external DDR3 device from power-up to the point where its mode registers can be loaded. On a start request it drives the memory reset control to its asserted level for a fixed hold time, then releases it. It keeps clock enable low through a fixed settle wait and then through a further programmable delay. After that it raises clock enable and sends a one-cycle kick to a downstream initialisation engine. It then waits for that engine to report completion, and gives up with an error if completion does not come within a bounded window.

All times are given in microseconds and turned into whole clock cycles through a cycles-per-microsecond parameter. The programmable delay is a 17-bit count scaled by a build-time multiplier of 2 or 3. The reset control can be driven in either polarity, so it suits boards where the reset line passes through an inverter. The engine that issues mode-register commands, impedance calibration and the PHY are outside this block.

Top module: `ddr3_pwrup_seq`

## Requirements
- R1: After an accepted start, the reset control sits at its asserted level for exactly RST_HOLD_US × CYC_PER_US cycles, beginning in the cycle after the start is sampled, and is then released.
- R2: Clock enable is low from an accepted start until at least CKE_WAIT_US × CYC_PER_US cycles after reset release. This fixed wait begins at release.
- R3: After the fixed wait, a further delay of cke_dly_i × CKE_MULT cycles follows before clock enable rises. The two waits run one after the other. cke_dly_i is captured when the start is accepted, and later changes to it have no effect. A value of 0 adds no delay.
- R4: With rst_inv_i = 0 the asserted level of mem_rst_o is 0 and the released level is 1. With rst_inv_i = 1 the asserted level is 1 and the released level is 0.
- R5: init_start_o is high for exactly one cycle: the first cycle in which clock enable is high.
- R6: When init_done_i is high in one of the TIMEOUT_US × CYC_PER_US cycles that follow the init_start_o cycle, done_o pulses for one cycle in the next cycle, and busy_o is low in that same cycle. Clock enable stays high.
- R7: When init_done_i stays low for that whole window, timeout_o rises in the cycle after the window ends and busy_o drops. Completion seen in the last cycle of the window takes precedence over the timeout. done_o and timeout_o are never high together.
- R8: A start request while busy_o is high is ignored. It does not change the timing of the current run, and it does not queue a new run.
- R9: After reset, mem_rst_o is at its asserted level, and mem_cke_o, busy_o, done_o, timeout_o and init_start_o are all 0.
- R10: An accepted start clears timeout_o, drops clock enable and re-asserts the reset control in the next cycle. busy_o is high from that cycle until done_o or timeout_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, sampled while idle |
| cke_dly_i | input | DLY_W | Extra clock-enable delay, counted in units of CKE_MULT cycles |
| rst_inv_i | input | 1 | Reset control polarity: 1 means the asserted level is high |
| init_done_i | input | 1 | Completion report from the initialisation engine |
| mem_rst_o | output | 1 | Reset control to the memory device |
| mem_cke_o | output | 1 | Clock enable to the memory device |
| init_start_o | output | 1 | One-cycle kick to the initialisation engine |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Completion timed out; held until the next accepted start |

## Verification
The assertions assume that rst_inv_i is held steady while a reset hold is in progress. They also assume that init_done_i means something only in the completion window, and that the time parameters make each phase at least one cycle long. The stimulus changes polarity and the delay value only between runs, or on the start cycle itself. It raises init_done_i for a single cycle at a chosen offset into the window, and it deliberately changes cke_dly_i after capture and pulses start mid-run. The bench shrinks the timeout to a short window through a parameter so that both the timeout path and the last-cycle completion corner can be reached.

// File: rtl/ddrpu_pkg.sv
package ddrpu_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RST_HOLD,
    PH_CKE_WAIT,
    PH_CKE_DLY,
    PH_INIT_KICK,
    PH_INIT_WAIT
  } ddrpu_phase_e;

  // Microseconds to whole clock cycles.
  function automatic longint unsigned us_to_cycles(longint unsigned us,
                                                   longint unsigned cyc_per_us);
    return us * cyc_per_us;
  endfunction

  // Programmable clock-enable delay in cycles.
  function automatic longint unsigned cke_extra_cycles(longint unsigned dly,
                                                       longint unsigned mult);
    return dly * mult;
  endfunction

endpackage

// File: rtl/ddrpu_phase_timer.sv
module ddrpu_phase_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_o <= '0;
    else if (clr_i)            cnt_o <= '0;
    else if (cnt_o != '1)      cnt_o <= cnt_o + 1'b1;
  end

endmodule

// File: rtl/ddrpu_pin_drive.sv
module ddrpu_pin_drive #(
  parameter longint unsigned HOLD_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic release_i,
  input  logic cke_on_i,
  input  logic inv_i,
  output logic released_o,
  output logic mem_rst_o,
  output logic mem_cke_o
);

  logic rel_q, cke_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rel_q <= 1'b0;
      cke_q <= 1'b0;
    end else if (arm_i) begin
      rel_q <= 1'b0;
      cke_q <= 1'b0;
    end else begin
      if (release_i) rel_q <= 1'b1;
      if (cke_on_i)  cke_q <= 1'b1;
    end
  end

  // Asserted level equals inv_i; released level is its complement.
  assign mem_rst_o  = inv_i ^ rel_q;
  assign mem_cke_o  = cke_q;
  assign released_o = rel_q;

  // Checker: cycles spent with reset asserted, saturating.
  logic [31:0] held_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)             held_cnt <= '0;
    else if (rel_q)         held_cnt <= '0;
    else if (held_cnt != '1) held_cnt <= held_cnt + 1'b1;
  end

  assert_reset_hold_min_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rel_q) |-> (longint'(held_cnt) >= longint'(HOLD_CYC)));

  assert_cke_needs_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cke_q |-> rel_q);

endmodule

// File: rtl/ddr3_pwrup_seq.sv
module ddr3_pwrup_seq
  import ddrpu_pkg::*;
#(
  parameter int unsigned CYC_PER_US  = 400,
  parameter int unsigned RST_HOLD_US = 200,
  parameter int unsigned CKE_WAIT_US = 500,
  parameter int unsigned TIMEOUT_US  = 1000000,
  parameter int unsigned CKE_MULT    = 2,
  parameter int unsigned DLY_W       = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DLY_W-1:0] cke_dly_i,
  input  logic             rst_inv_i,
  input  logic             init_done_i,
  output logic             mem_rst_o,
  output logic             mem_cke_o,
  output logic             init_start_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             timeout_o
);

  localparam longint unsigned HOLD_CYC = us_to_cycles(RST_HOLD_US, CYC_PER_US);
  localparam longint unsigned WAIT_CYC = us_to_cycles(CKE_WAIT_US, CYC_PER_US);
  localparam longint unsigned TO_CYC   = us_to_cycles(TIMEOUT_US, CYC_PER_US);
  localparam longint unsigned DLY_MAX  = cke_extra_cycles((64'd1 << DLY_W) - 1, CKE_MULT);
  localparam longint unsigned MAX_AB   = (HOLD_CYC > WAIT_CYC) ? HOLD_CYC : WAIT_CYC;
  localparam longint unsigned MAX_CD   = (TO_CYC > DLY_MAX) ? TO_CYC : DLY_MAX;
  localparam longint unsigned CNT_MAX  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int unsigned     CNT_W    = $clog2(CNT_MAX + 1);

  ddrpu_phase_e     phase_q, phase_d;
  logic [DLY_W-1:0] dly_q;
  logic             done_q, err_q;
  logic [CNT_W-1:0] cnt, phase_len;
  logic             last;

  // Named internal events
  logic start_ok, rel_ev, cke_ev, done_ev, to_ev, phase_chg;
  logic released;

  ddrpu_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (phase_chg),
    .cnt_o (cnt)
  );

  always_comb begin
    unique case (phase_q)
      PH_RST_HOLD:  phase_len = CNT_W'(HOLD_CYC);
      PH_CKE_WAIT:  phase_len = CNT_W'(WAIT_CYC);
      PH_CKE_DLY:   phase_len = CNT_W'(cke_extra_cycles(longint'(dly_q), CKE_MULT));
      PH_INIT_WAIT: phase_len = CNT_W'(TO_CYC);
      default:      phase_len = CNT_W'(1);
    endcase
  end

  assign last = ({1'b0, cnt} + 1'b1) == {1'b0, phase_len};

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:      if (start_i) phase_d = PH_RST_HOLD;
      PH_RST_HOLD:  if (last) phase_d = PH_CKE_WAIT;
      PH_CKE_WAIT:  if (last) phase_d = (dly_q == '0) ? PH_INIT_KICK : PH_CKE_DLY;
      PH_CKE_DLY:   if (last) phase_d = PH_INIT_KICK;
      PH_INIT_KICK: phase_d = PH_INIT_WAIT;
      PH_INIT_WAIT: if (init_done_i || last) phase_d = PH_IDLE;
      default:      phase_d = PH_IDLE;
    endcase
  end

  assign phase_chg = phase_d != phase_q;
  assign start_ok  = (phase_q == PH_IDLE) && start_i;
  assign rel_ev    = (phase_q == PH_RST_HOLD) && last;
  assign cke_ev    = (phase_d == PH_INIT_KICK) && (phase_q != PH_INIT_KICK);
  assign done_ev   = (phase_q == PH_INIT_WAIT) && init_done_i;
  assign to_ev     = (phase_q == PH_INIT_WAIT) && !init_done_i && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      dly_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= done_ev;
      if (start_ok) dly_q <= cke_dly_i;
      if (start_ok)   err_q <= 1'b0;
      else if (to_ev) err_q <= 1'b1;
    end
  end

  ddrpu_pin_drive #(.HOLD_CYC(HOLD_CYC)) u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_i      (start_ok),
    .release_i  (rel_ev),
    .cke_on_i   (cke_ev),
    .inv_i      (rst_inv_i),
    .released_o (released),
    .mem_rst_o  (mem_rst_o),
    .mem_cke_o  (mem_cke_o)
  );

  assign init_start_o = phase_q == PH_INIT_KICK;
  assign busy_o       = phase_q != PH_IDLE;
  assign done_o       = done_q;
  assign timeout_o    = err_q;

  // Checker counters: cycles since release, cycles since the kick.
  logic [31:0] rel_cnt, wait_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rel_cnt  <= '0;
      wait_cnt <= '0;
    end else begin
      if (!released)           rel_cnt <= '0;
      else if (rel_cnt != '1)  rel_cnt <= rel_cnt + 1'b1;
      if (init_start_o)        wait_cnt <= '0;
      else if (wait_cnt != '1) wait_cnt <= wait_cnt + 1'b1;
    end
  end

  // R2 and R3: both waits elapse in sequence before clock enable rises
  assert_cke_after_waits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cke_o) |->
      (longint'(rel_cnt) >= longint'(WAIT_CYC) + longint'(cke_extra_cycles(longint'(dly_q), CKE_MULT))));

  assert_kick_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    init_start_o |=> !init_start_o);

  assert_kick_with_cke_R5: assert property (@(posedge clk) disable iff (!rst_n)
    init_start_o |-> mem_cke_o);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_timeout_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_o) |-> (longint'(wait_cnt) >= longint'(TO_CYC)));

  assert_done_err_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && timeout_o));

  assert_busy_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_ev && !to_ev) |=> busy_o);

endmodule

// File: tb/ddr3_pwrup_seq_tb.sv
module ddr3_pwrup_seq_tb;

  localparam int CPU   = 2;
  localparam int MULT  = 3;
  localparam int TO_US = 50;

  function automatic int us2cyc(int us);
    int acc = 0;
    for (int i = 0; i < CPU; i++) acc += us;
    return acc;
  endfunction

  localparam int H  = 200 * CPU;
  localparam int W  = 500 * CPU;
  localparam int TO = TO_US * CPU;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [16:0] cke_dly_i = '0;
  logic        rst_inv_i = 1'b0;
  logic        init_done_i = 1'b0;
  logic        mem_rst_o, mem_cke_o, init_start_o, busy_o, done_o, timeout_o;

  always #4 clk = ~clk;

  ddr3_pwrup_seq #(
    .CYC_PER_US(CPU), .RST_HOLD_US(200), .CKE_WAIT_US(500),
    .TIMEOUT_US(TO_US), .CKE_MULT(MULT), .DLY_W(17)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cke_dly_i(cke_dly_i),
    .rst_inv_i(rst_inv_i), .init_done_i(init_done_i), .mem_rst_o(mem_rst_o),
    .mem_cke_o(mem_cke_o), .init_start_o(init_start_o), .busy_o(busy_o),
    .done_o(done_o), .timeout_o(timeout_o)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int  checks = 0;
  int  fails  = 0;
  bit  finished = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [16:0] dly, input bit inv, input int lat, input bit poke);
    int k;
    int t_rel = -1, t_cke = -1, t_is = -1, n_is = 0, t_done = -1, n_done = 0, t_to = -1;
    int c;
    int lvl_late = -1;
    int d = dly * MULT;
    @(negedge clk);
    cke_dly_i = dly; rst_inv_i = inv; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    k = cyc;
    cke_dly_i = dly ^ 17'h0000f;  // changed after capture: must not matter (R3)
    chk("R4",  "reset level at start", mem_rst_o, inv);
    chk("R10", "cke low after start", mem_cke_o, 0);
    chk("R10", "timeout cleared by start", timeout_o, 0);
    chk("R10", "busy after start", busy_o, 1);
    for (int i = 0; i < 8000; i++) begin
      c = cyc;
      if (c == k + H - 1) lvl_late = mem_rst_o;
      if (t_rel < 0 && mem_rst_o != inv) t_rel = c;
      if (t_cke < 0 && mem_cke_o) t_cke = c;
      if (init_start_o) begin n_is++; if (t_is < 0) t_is = c; end
      if (done_o) begin n_done++; t_done = c; end
      if (timeout_o && t_to < 0) t_to = c;
      if (!busy_o && c > k && (done_o || timeout_o)) break;
      init_done_i = (t_is >= 0) && (c == t_is + 1 + lat);
      start_i = poke && (c == k + 5 || c == t_is + 1);
      @(negedge clk);
    end
    init_done_i = 1'b0;
    start_i = 1'b0;
    chk("R4", "reset still asserted at hold end", lvl_late, inv);
    chk("R1", "release cycle", t_rel, k + H);
    chk("R3", "cke rise cycle (fixed wait then extra delay)", t_cke, k + us2cyc(200) + us2cyc(500) + d);
    chk("R5", "kick cycle equals cke rise", t_is, t_cke);
    chk("R5", "kick pulse count", n_is, 1);
    chk("R8", "poke does not alter timing", t_rel - k, H);
    if (lat < TO) begin
      chk("R6", "done cycle", t_done, t_is + 2 + lat);
      chk("R6", "done pulse count", n_done, 1);
      chk("R7", "no timeout when done in window", t_to, -1);
    end else begin
      chk("R7", "timeout cycle", t_to, t_is + 1 + TO);
      chk("R7", "no done on timeout", n_done, 0);
    end
    @(negedge clk);
    chk("R6", "done is one cycle", done_o, 0);
    @(negedge clk);
    chk("R8", "no queued run", busy_o, 0);
    chk("R6", "cke stays high", mem_cke_o, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "reset control asserted", mem_rst_o, 0);
    chk("R9", "cke", mem_cke_o, 0);
    chk("R9", "busy", busy_o, 0);
    chk("R9", "done", done_o, 0);
    chk("R9", "timeout", timeout_o, 0);
    chk("R9", "kick", init_start_o, 0);
    rst_inv_i = 1'b1;
    @(negedge clk);
    chk("R4", "inverted idle level", mem_rst_o, 1);
    rst_inv_i = 1'b0;

    run(17'd0, 1'b0, 0, 1'b0);        // no extra delay, immediate done
    run(17'd1, 1'b1, TO - 1, 1'b1);   // done on last window cycle
    run(17'd5, 1'b0, TO, 1'b0);       // timeout
    run(17'd2, 1'b1, 3, 1'b0);        // start after timeout clears it
    run(17'd7, 1'b0, TO + 20, 1'b1);  // timeout with pokes
    for (int r = 0; r < 8; r++) begin
      run(17'($urandom_range(0, 25)), 1'($urandom_range(0, 1)),
          int'($urandom_range(0, TO + 10)), 1'($urandom_range(0, 1)));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule